// File: doc/BRIEF.md
# Hot-swap card presence and fault status

This block holds the card-presence state and the sticky fault status of a hot-swap switch controller. An active-low presence pin (pulled high when no card is fitted) is synchronized and watched for edges. A card leaving forces the switch gate off at once and drops the presence bit. A card arriving wipes the old fault history and marks the card present. Once the pin has stayed low for a qualification time, the level of an ON strap pin is captured into a FET-on bit, and that bit turns the gate on.

Two analog conditions arrive as comparator bits. The first is a sense voltage at or above the short threshold while the gate is low, which records a FET-short fault. The second is feedback undervoltage while the gate is high and the gate drive is adequate. When this lasts a deglitch time, it records a power-bad fault, raises a live power-bad-present flag and pulls the power-good open-drain output low. Recovery releases the output but keeps the fault bit. A test port can clear fault bits through a mask and can write the FET-on bit.

Top module: `hsw_presence_fault`

## Requirements
- R1: Every edge of the synchronized presence pin, falling or rising, sets fault bit 4 (change of state).
- R2: A rising presence pin (removal) raises `gateKill` for exactly one cycle. On the next edge it clears the presence bit and the FET-on bit, so `gateEn` drops.
- R3: A falling presence pin (insertion) clears every fault bit except bit 4 and sets the presence bit.
- R4: When the pin has stayed low for QUAL_CYCLES cycles after the insertion is detected, `onPin` is captured into the FET-on bit. `gateEn` equals FET-on AND presence.
- R5: The qualification timer restarts on every insertion and is cancelled by a removal, so a second insertion needs its own full QUAL_CYCLES.
- R6: A synchronized `senseOver` while `gateHigh` is low sets fault bit 5 (FET short). While `gateHigh` is high it sets nothing.
- R7: Feedback undervoltage held for DG_CYCLES consecutive synchronized cycles, with `gateHigh` and `gsOk` both high, sets fault bit 3 and `pbadPresent` and drives `pgoodRelease` low. A shorter pulse has no effect.
- R8: No power-bad state is recorded while `gsOk` is low or while `gateHigh` is low.
- R9: When feedback recovers, `pbadPresent` clears and `pgoodRelease` returns high. Fault bit 3 stays set.
- R10: A `faultClr` pulse clears the fault bits selected by `faultClrMask`. A fault being set in the same cycle survives the clear.
- R11: After reset: presence, FET-on and power-bad-present are 0, all fault bits are 0, `gateEn` and `gateKill` are 0, and `pgoodRelease` is 1.
- R12: A `fetWr` pulse loads `fetWrVal` into the FET-on bit on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enPinN | input | 1 | Presence pin, low = card fitted (asynchronous) |
| onPin | input | 1 | ON strap level |
| gateHigh | input | 1 | Gate drive is high |
| gsOk | input | 1 | Gate-to-source voltage is adequate |
| fbUnder | input | 1 | Feedback below threshold (asynchronous) |
| senseOver | input | 1 | Sense voltage at or above short threshold (asynchronous) |
| faultClr | input | 1 | Fault clear strobe |
| faultClrMask | input | 8 | Fault bits to clear |
| fetWr | input | 1 | FET-on write strobe |
| fetWrVal | input | 1 | Value for FET-on write |
| gateEn | output | 1 | Gate enable |
| gateKill | output | 1 | One-cycle fast gate-off strobe on removal |
| pgoodRelease | output | 1 | Power-good open drain: 1 = high impedance, 0 = pulled low |
| presentBit | output | 1 | Card presence control bit |
| pbadPresent | output | 1 | Live power-bad control bit |
| fetOn | output | 1 | FET-on control bit |
| faultBits | output | 8 | Sticky fault register (bit 3 power bad, 4 change of state, 5 FET short) |

## Verification
The hardest situation to reach is a qualification timer restarted part way through its count. From the outside that looks the same as a normal insertion unless the bench times it exactly. The stimulus inserts the card, removes it twenty cycles later, inserts it again, and then checks that FET-on is still clear one cycle before a full window measured from the second insertion and set one cycle after. The deglitch boundary is found the same way: a pulse one cycle short is followed by a held undervoltage, which is sampled on both sides of its qualifying edge.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  localparam int FAULT_W   = 8;
  localparam int PBAD_BIT  = 3;
  localparam int COS_BIT   = 4;
  localparam int SHORT_BIT = 5;

  typedef struct packed {
    logic insertStb;   // presence pin fell
    logic removeStb;   // presence pin rose
    logic latchOnStb;  // qualification window elapsed
    logic pbadSetStb;  // deglitched power-bad qualified
    logic pbadClrStb;  // feedback back above threshold
    logic shortStb;    // sense over threshold with gate off
  } hswStrobeT;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
#(
  parameter int QUAL_CYCLES = 5_000_000,
  parameter int DG_CYCLES   = 100
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enPinN,
  input  logic      fbUnder,
  input  logic      senseOver,
  input  logic      gateHigh,
  input  logic      gsOk,
  output hswStrobeT stb
);
  localparam int NSYNC = 3;
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b100;
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam int DW = $clog2(DG_CYCLES + 1);
  localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_CYCLES - 1);
  localparam logic [DW-1:0] DG_LAST   = DW'(DG_CYCLES - 1);

  logic [NSYNC-1:0] rawIn, syncOut;
  assign rawIn = {enPinN, fbUnder, senseOver};

  generate
    for (genvar i = 0; i < NSYNC; i++) begin : g_sync
      hsw_sync #(.RST_VAL(SYNC_RST[i])) u_sync (
        .clk(clk), .rstN(rstN), .din(rawIn[i]), .dout(syncOut[i])
      );
    end
  endgenerate

  logic enS, fbS, soS, enPrev;
  assign enS = syncOut[2];
  assign fbS = syncOut[1];
  assign soS = syncOut[0];

  logic insert, remove;
  assign insert = enPrev & ~enS;
  assign remove = ~enPrev & enS;

  logic qualActive;
  logic [QW-1:0] qualCnt;
  logic latchOn;
  assign latchOn = qualActive && !enS && (qualCnt == QUAL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev     <= 1'b1;
      qualActive <= 1'b0;
      qualCnt    <= '0;
    end else begin
      enPrev <= enS;
      if (insert) begin
        qualActive <= 1'b1;
        qualCnt    <= '0;
      end else if (remove || latchOn) begin
        qualActive <= 1'b0;
      end else if (qualActive) begin
        qualCnt <= qualCnt + 1'b1;
      end
    end
  end

  logic pbCond;
  logic [DW-1:0] pbCnt;
  assign pbCond = fbS && gateHigh && gsOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pbCnt <= '0;
    else if (!pbCond)     pbCnt <= '0;
    else if (pbCnt != DG_LAST) pbCnt <= pbCnt + 1'b1;
  end

  always_comb begin
    stb            = '0;
    stb.insertStb  = insert;
    stb.removeStb  = remove;
    stb.latchOnStb = latchOn;
    stb.pbadSetStb = pbCond && (pbCnt == DG_LAST);
    stb.pbadClrStb = ~fbS;
    stb.shortStb   = soS & ~gateHigh;
  end

  // R5
  qual_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    remove |=> !qualActive);
  // R4
  qual_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    insert |=> (qualActive && qualCnt == '0));
endmodule

// File: rtl/hsw_regs.sv
module hsw_regs
  import hsw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  hswStrobeT          stb,
  input  logic               onPin,
  input  logic               faultClr,
  input  logic [FAULT_W-1:0] faultClrMask,
  input  logic               fetWr,
  input  logic               fetWrVal,
  output logic               presentBit,
  output logic               fetOn,
  output logic               pbadPresent,
  output logic [FAULT_W-1:0] faultQ
);
  localparam logic [FAULT_W-1:0] COS_ONLY = FAULT_W'(1) << COS_BIT;

  logic [FAULT_W-1:0] faultKeep, faultSet, faultNext;

  always_comb begin
    faultKeep = faultQ;
    if (stb.insertStb) faultKeep = faultKeep & COS_ONLY;
    if (faultClr)      faultKeep = faultKeep & ~faultClrMask;
    faultSet            = '0;
    faultSet[COS_BIT]   = stb.insertStb | stb.removeStb;
    faultSet[SHORT_BIT] = stb.shortStb;
    faultSet[PBAD_BIT]  = stb.pbadSetStb;
    faultNext = faultKeep | faultSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultQ      <= '0;
      presentBit  <= 1'b0;
      fetOn       <= 1'b0;
      pbadPresent <= 1'b0;
    end else begin
      faultQ <= faultNext;
      if (stb.removeStb)      presentBit <= 1'b0;
      else if (stb.insertStb) presentBit <= 1'b1;
      if (stb.removeStb)       fetOn <= 1'b0;
      else if (stb.latchOnStb) fetOn <= onPin;
      else if (fetWr)          fetOn <= fetWrVal;
      if (stb.pbadSetStb)      pbadPresent <= 1'b1;
      else if (stb.pbadClrStb) pbadPresent <= 1'b0;
    end
  end

  // R2
  remove_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.removeStb |=> (!presentBit && !fetOn));
  // R3
  insert_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.insertStb |=> (presentBit && faultQ[COS_BIT]));
  // R1
  cos_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultQ[COS_BIT]) |-> $past(stb.insertStb || stb.removeStb));
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultClr && stb.shortStb) |=> faultQ[SHORT_BIT]);
  // R4
  latch_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchOnStb |=> (fetOn == $past(onPin)));
endmodule

// File: rtl/hsw_presence_fault.sv
module hsw_presence_fault
  import hsw_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int QUAL_US     = 100_000,
  parameter int DEGLITCH_NS = 2000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enPinN,
  input  logic               onPin,
  input  logic               gateHigh,
  input  logic               gsOk,
  input  logic               fbUnder,
  input  logic               senseOver,
  input  logic               faultClr,
  input  logic [FAULT_W-1:0] faultClrMask,
  input  logic               fetWr,
  input  logic               fetWrVal,
  output logic               gateEn,
  output logic               gateKill,
  output logic               pgoodRelease,
  output logic               presentBit,
  output logic               pbadPresent,
  output logic               fetOn,
  output logic [FAULT_W-1:0] faultBits
);
  localparam int CYC_PER_US  = CLK_HZ / 1_000_000;
  localparam int QUAL_CYCLES = CYC_PER_US * QUAL_US;
  localparam int DG_RAW      = (CYC_PER_US * DEGLITCH_NS) / 1000;
  localparam int DG_CYCLES   = (DG_RAW < 1) ? 1 : DG_RAW;

  hswStrobeT stb;

  hsw_ctrl #(.QUAL_CYCLES(QUAL_CYCLES), .DG_CYCLES(DG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enPinN(enPinN), .fbUnder(fbUnder),
    .senseOver(senseOver), .gateHigh(gateHigh), .gsOk(gsOk), .stb(stb)
  );

  hsw_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .onPin(onPin),
    .faultClr(faultClr), .faultClrMask(faultClrMask),
    .fetWr(fetWr), .fetWrVal(fetWrVal),
    .presentBit(presentBit), .fetOn(fetOn),
    .pbadPresent(pbadPresent), .faultQ(faultBits)
  );

  assign gateEn       = fetOn & presentBit;
  assign gateKill     = stb.removeStb;
  assign pgoodRelease = ~pbadPresent;

  // R8
  pbad_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pbadPresent) |-> $past(gsOk && gateHigh));
endmodule

// File: tb/hsw_presence_fault_tb.sv
`timescale 1ns/1ps
module hsw_presence_fault_tb;
  localparam int Q = 50;  // 50 MHz, 1 us window
  localparam int D = 5;   // 50 MHz, 100 ns deglitch

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enPinN = 1'b1, onPin = 1'b0, gateHigh = 1'b0, gsOk = 1'b0;
  logic fbUnder = 1'b0, senseOver = 1'b0, faultClr = 1'b0;
  logic [7:0] faultClrMask = 8'h00;
  logic fetWr = 1'b0, fetWrVal = 1'b0;
  logic gateEn, gateKill, pgoodRelease, presentBit, pbadPresent, fetOn;
  logic [7:0] faultBits;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hsw_presence_fault #(.CLK_HZ(50_000_000), .QUAL_US(1), .DEGLITCH_NS(100)) u_dut (
    .clk(clk), .rstN(rstN), .enPinN(enPinN), .onPin(onPin), .gateHigh(gateHigh),
    .gsOk(gsOk), .fbUnder(fbUnder), .senseOver(senseOver), .faultClr(faultClr),
    .faultClrMask(faultClrMask), .fetWr(fetWr), .fetWrVal(fetWrVal),
    .gateEn(gateEn), .gateKill(gateKill), .pgoodRelease(pgoodRelease),
    .presentBit(presentBit), .pbadPresent(pbadPresent), .fetOn(fetOn),
    .faultBits(faultBits)
  );

  // observed = {present, fetOn, pbadPresent, gateEn, pgoodRelease, faults}
  typedef struct packed {
    logic [3:0]  req;
    logic [5:0]  pins;   // {enPinN, onPin, gateHigh, gsOk, fbUnder, senseOver}
    logic [7:0]  waitN;
    logic [12:0] exp;
  } vecT;

  localparam int NV = 10;
  localparam vecT VECS [NV] = '{
    '{4'd3, 6'b010000, 8'd3,  {5'b10001, 8'h10}},  // R3 R1 insertion
    '{4'd4, 6'b010000, 8'd51, {5'b11011, 8'h10}},  // R4 ON latched
    '{4'd7, 6'b011110, 8'd8,  {5'b11110, 8'h18}},  // R7 power bad
    '{4'd9, 6'b011100, 8'd3,  {5'b11011, 8'h18}},  // R9 recovery
    '{4'd8, 6'b011010, 8'd20, {5'b11011, 8'h18}},  // R8 gsOk low masks
    '{4'd6, 6'b010101, 8'd3,  {5'b11011, 8'h38}},  // R6 short with gate low
    '{4'd2, 6'b110100, 8'd3,  {5'b00001, 8'h38}},  // R2 removal
    '{4'd3, 6'b010100, 8'd3,  {5'b10001, 8'h10}},  // R3 reinsertion clears
    '{4'd4, 6'b000100, 8'd55, {5'b10001, 8'h10}},  // R4 ON low latched
    '{4'd6, 6'b001101, 8'd5,  {5'b10001, 8'h10}}   // R6 no short with gate high
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clrPulse(input logic [7:0] m);
    faultClr = 1'b1; faultClrMask = m;
    step(1);
    faultClr = 1'b0; faultClrMask = 8'h00;
  endtask

  task automatic fetWrite(input logic v);
    fetWr = 1'b1; fetWrVal = v;
    step(1);
    fetWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    // R11 reset state
    check("R11", {presentBit, fetOn, pbadPresent, gateEn, pgoodRelease, gateKill, faultBits},
          {6'b000010, 8'h00});
    rstN = 1'b1;
    step(4);
    check("R11", {presentBit, fetOn, pbadPresent, gateEn, pgoodRelease, faultBits},
          {5'b00001, 8'h00});

    for (int i = 0; i < NV; i++) begin
      {enPinN, onPin, gateHigh, gsOk, fbUnder, senseOver} = VECS[i].pins;
      step(int'(VECS[i].waitN));
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {19'd0, presentBit, fetOn, pbadPresent, gateEn, pgoodRelease, faultBits},
            {19'd0, VECS[i].exp});
    end

    enPinN = 1'b0; onPin = 1'b0; gateHigh = 1'b0; gsOk = 1'b1; fbUnder = 1'b0; senseOver = 1'b0;
    step(3);

    // R12 FET-on write port
    fetWrite(1'b1);
    check("R12", {fetOn, gateEn}, 2'b11);
    fetWrite(1'b0);
    check("R12", {fetOn, gateEn}, 2'b00);

    // R2 one-cycle gate kill on removal
    fetWrite(1'b1);
    enPinN = 1'b1;
    step(2);
    check("R2", {gateKill, gateEn}, 2'b11);
    step(1);
    check("R2", {gateKill, gateEn, presentBit}, 3'b000);

    // R4 exact qualification boundary
    onPin = 1'b1; enPinN = 1'b0;
    step(Q + 2);
    check("R4", fetOn, 1'b0);
    step(1);
    check("R4", {fetOn, gateEn}, 2'b11);

    // R5 timer restarts on second insertion
    enPinN = 1'b1; step(5);
    enPinN = 1'b0; step(20);
    enPinN = 1'b1; step(5);
    enPinN = 1'b0;
    step(Q + 2);
    check("R5", fetOn, 1'b0);
    step(1);
    check("R5", {fetOn, gateEn}, 2'b11);

    // R7 deglitch: short pulse ignored, held level qualifies at D cycles
    gateHigh = 1'b1; gsOk = 1'b1;
    fbUnder = 1'b1; step(D - 1);
    fbUnder = 1'b0; step(10);
    check("R7", {pbadPresent, faultBits[3], pgoodRelease}, 3'b001);
    fbUnder = 1'b1;
    step(D + 1);
    check("R7", pbadPresent, 1'b0);
    step(1);
    check("R7", {pbadPresent, pgoodRelease, faultBits}, {2'b10, 8'h18});
    fbUnder = 1'b0;
    step(3);
    check("R9", {pbadPresent, pgoodRelease, faultBits[3]}, 3'b011);

    // R10 clear with simultaneous set, then selective clear
    gateHigh = 1'b0; senseOver = 1'b1;
    step(3);
    check("R6", faultBits, 8'h38);
    clrPulse(8'hFF);
    check("R10", faultBits, 8'h20);
    senseOver = 1'b0;
    step(3);
    clrPulse(8'h10);
    check("R10", faultBits, 8'h20);
    clrPulse(8'h20);
    check("R10", faultBits, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule